// File: doc/BRIEF.md
# Decoded Micro-op Line Cache

This block keeps bundles of micro-ops that the legacy decoder has already produced, so the front end can skip decoding when a fetch window repeats. A lookup presents the address of a 64-byte fetch window and a thread number. One cycle later the block reports hit or miss. On a hit it also returns the whole stored bundle of up to six micro-ops, a per-slot valid mask and a flag that marks the bundle as a pointer into microcode. The decode queue behind it takes the bundle in one beat.

The default storage is 48 sets of 8 ways with six 16-bit slots per line. The number of sets is not a power of two, so the set is the window address modulo the set count and the quotient serves as the tag. Every line also stores the thread number. Both threads compete for every way of every set, and lines from different threads never match each other.

A fill port writes a line after the decoder has built it. The fill replaces a line that already holds the same window and thread. If there is none it takes a free way, and if the set is full it takes the victim of a per-set tree pseudo-LRU. An invalidation port removes every line of one window for both threads, which keeps the contents inclusive with the instruction cache. When a lookup and a fill address the same set in the same cycle, the lookup is served and the fill is refused for that cycle.

Top module: `uopc_cache`

## Requirements
- R1: The set of a window address is the address modulo NSETS and its tag is the integer quotient. A lookup hits only in its own set, on a valid line whose tag and thread both match.
- R2: A lookup presented in cycle N gives rd_valid=1 in cycle N+1, with rd_hit showing hit or miss. On a hit, slot i of the stored bundle appears on rd_uops[i*UOP_W +: UOP_W]. Without a lookup, rd_valid and rd_hit are 0.
- R3: A line is filled with a slot count c from 1 to SLOTS. A hit drives rd_slot_vld to the c lowest bits set and forces the uop slots at and above c to zero. A miss drives rd_slot_vld, rd_uops and rd_ucode to zero.
- R4: The microcode-pointer flag given with a fill comes back on rd_ucode on every hit to that line.
- R5: A line filled by one thread never hits for the other thread. A single thread may occupy all NWAYS ways of a set.
- R6: A fill whose window and thread are already present overwrites that line in place. Otherwise it takes the lowest-numbered free way. Otherwise it takes the pseudo-LRU victim.
- R7: Each set keeps NWAYS-1 tree bits in heap order (node k has children 2k+1 and 2k+2). A bit of 0 sends the victim walk to the lower half and a 1 sends it to the upper half. Touching a way sets each bit on its path to point away from that way. A lookup hit and an accepted fill both touch their way.
- R8: An invalidation removes the lines of its window for both threads from the next cycle on. A lookup in the same cycle still sees the lines as they were before the invalidation.
- R9: fl_ready is low in the same cycle when a lookup or an invalidation addresses the fill's set. A refused fill writes nothing and touches nothing. A fill to any other set proceeds in that cycle.
- R10: After reset, all lines are invalid, all tree bits are 0 and every rd_* output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | 1 | Lookup thread |
| lk_win | input | WIN_W | Lookup fetch-window address (byte address / 64) |
| fl_valid | input | 1 | Fill request |
| fl_tid | input | 1 | Fill thread |
| fl_win | input | WIN_W | Fill fetch-window address |
| fl_count | input | $clog2(SLOTS+1) | Number of valid slots, 1..SLOTS |
| fl_ucode | input | 1 | Bundle is a microcode pointer |
| fl_uops | input | SLOTS*UOP_W | Micro-op slots, slot i at bits i*UOP_W |
| fl_ready | output | 1 | Fill accepted this cycle |
| inv_valid | input | 1 | Invalidate request |
| inv_win | input | WIN_W | Window to remove, both threads |
| rd_valid | output | 1 | Lookup result present |
| rd_hit | output | 1 | Lookup hit |
| rd_ucode | output | 1 | Hit line is a microcode pointer |
| rd_slot_vld | output | SLOTS | Per-slot valid mask |
| rd_uops | output | SLOTS*UOP_W | Returned micro-op slots |

## Verification
Lookup results come out of a register, so every rd_* output is due exactly one cycle after the lookup. fl_ready is combinational and is due in the same cycle as the fill that it answers. The bench drives its inputs on the falling edge. It checks fl_ready a moment after driving them, then runs its reference model on those inputs to predict the rd_* values, and compares those values on the next falling edge. Directed probes follow the same spacing: they state a hit or miss by hand and read it one rising edge after the request.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int unsigned UC_SETS  = 48;
  localparam int unsigned UC_WAYS  = 8;
  localparam int unsigned UC_SLOTS = 6;
  localparam int unsigned UC_UOP_W = 16;
  localparam int unsigned UC_WIN_W = 26;

  typedef enum logic [1:0] {
    FW_NONE   = 2'd0,
    FW_MATCH  = 2'd1,
    FW_FREE   = 2'd2,
    FW_VICTIM = 2'd3
  } fill_src_e;
endpackage

// File: rtl/uc_tag_match.sv
module uc_tag_match #(
  parameter int unsigned NWAYS = 8,
  parameter int unsigned TAG_W = 21
) (
  input  logic [NWAYS-1:0]            vld,
  input  logic [NWAYS-1:0][TAG_W-1:0] tags,
  input  logic [NWAYS-1:0]            tids,
  input  logic [TAG_W-1:0]            q_tag,
  input  logic                        q_tid,
  input  logic                        use_tid,
  output logic [NWAYS-1:0]            match
);
  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    assign match[g] = vld[g] && (tags[g] == q_tag) && (!use_tid || (tids[g] == q_tid));
  end
endmodule

// File: rtl/uc_plru.sv
module uc_plru #(
  parameter int unsigned NSETS = 48,
  parameter int unsigned NWAYS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NSETS)-1:0] vic_set,
  output logic [$clog2(NWAYS)-1:0] vic_way,
  input  logic                     ta_en,
  input  logic [$clog2(NSETS)-1:0] ta_set,
  input  logic [$clog2(NWAYS)-1:0] ta_way,
  input  logic                     tb_en,
  input  logic [$clog2(NSETS)-1:0] tb_set,
  input  logic [$clog2(NWAYS)-1:0] tb_way
);
  localparam int unsigned WAY_W = $clog2(NWAYS);
  localparam int unsigned NODES = NWAYS - 1;

  logic [NODES-1:0] tree_q [NSETS];

  function automatic logic [WAY_W-1:0] walk_victim(input logic [NODES-1:0] t);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + (t[n-1] ? 1 : 0);
    return WAY_W'(n - NWAYS);
  endfunction

  function automatic logic [NODES-1:0] point_away(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    int unsigned n;
    logic d;
    n = 1;
    for (int l = 0; l < WAY_W; l++) begin
      d = w[WAY_W-1-l];
      t[n-1] = ~d;
      n = 2 * n + (d ? 1 : 0);
    end
    return t;
  endfunction

  assign vic_way = walk_victim(tree_q[vic_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) tree_q[s] <= '0;
    end else begin
      if (ta_en) tree_q[ta_set] <= point_away(tree_q[ta_set], ta_way);
      if (tb_en) tree_q[tb_set] <= point_away(tree_q[tb_set], tb_way);
    end
  end
endmodule

// File: rtl/uc_way_pick.sv
module uc_way_pick import uc_pkg::*; #(
  parameter int unsigned NWAYS = 8
) (
  input  logic [NWAYS-1:0]         vld,
  input  logic [NWAYS-1:0]         match,
  input  logic [$clog2(NWAYS)-1:0] victim,
  output logic [$clog2(NWAYS)-1:0] way,
  output fill_src_e                src
);
  localparam int unsigned WAY_W = $clog2(NWAYS);

  function automatic logic [WAY_W-1:0] lowest_one(input logic [NWAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = NWAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  always_comb begin
    if (|match) begin
      way = lowest_one(match);
      src = FW_MATCH;
    end else if (!(&vld)) begin
      way = lowest_one(~vld);
      src = FW_FREE;
    end else begin
      way = victim;
      src = FW_VICTIM;
    end
  end
endmodule

// File: rtl/uopc_cache.sv
module uopc_cache import uc_pkg::*; #(
  parameter int unsigned NSETS = UC_SETS,
  parameter int unsigned NWAYS = UC_WAYS,
  parameter int unsigned SLOTS = UC_SLOTS,
  parameter int unsigned UOP_W = UC_UOP_W,
  parameter int unsigned WIN_W = UC_WIN_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid,
  input  logic                         lk_tid,
  input  logic [WIN_W-1:0]             lk_win,
  input  logic                         fl_valid,
  input  logic                         fl_tid,
  input  logic [WIN_W-1:0]             fl_win,
  input  logic [$clog2(SLOTS+1)-1:0]   fl_count,
  input  logic                         fl_ucode,
  input  logic [SLOTS*UOP_W-1:0]       fl_uops,
  output logic                         fl_ready,
  input  logic                         inv_valid,
  input  logic [WIN_W-1:0]             inv_win,
  output logic                         rd_valid,
  output logic                         rd_hit,
  output logic                         rd_ucode,
  output logic [SLOTS-1:0]             rd_slot_vld,
  output logic [SLOTS*UOP_W-1:0]       rd_uops
);
  localparam int unsigned SET_W  = $clog2(NSETS);
  localparam int unsigned WAY_W  = $clog2(NWAYS);
  localparam int unsigned TAG_W  = WIN_W - SET_W + 1;
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned LINE_W = SLOTS * UOP_W;

  function automatic logic [SET_W-1:0] set_of(input logic [WIN_W-1:0] w);
    return SET_W'(w % WIN_W'(NSETS));
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WIN_W-1:0] w);
    return TAG_W'(w / WIN_W'(NSETS));
  endfunction

  function automatic logic [SLOTS-1:0] slot_mask(input logic [CNT_W-1:0] c);
    logic [SLOTS-1:0] m;
    for (int i = 0; i < SLOTS; i++) m[i] = (i < int'(c));
    return m;
  endfunction

  function automatic logic [LINE_W-1:0] lane_mask(input logic [SLOTS-1:0] m);
    logic [LINE_W-1:0] e;
    for (int i = 0; i < SLOTS; i++) e[i*UOP_W +: UOP_W] = {UOP_W{m[i]}};
    return e;
  endfunction

  // storage
  logic [NWAYS-1:0]             vld_q [NSETS];
  logic [NWAYS-1:0][TAG_W-1:0]  tag_q [NSETS];
  logic [NWAYS-1:0]             tid_q [NSETS];
  logic [NWAYS-1:0]             uc_q  [NSETS];
  logic [NWAYS-1:0][CNT_W-1:0]  cnt_q [NSETS];
  logic [NWAYS-1:0][LINE_W-1:0] dat_q [NSETS];

  // named internal events
  logic [SET_W-1:0] lk_set, fl_set, inv_set;
  logic [TAG_W-1:0] lk_tag, fl_tag, inv_tag;
  logic [NWAYS-1:0] lk_match, fl_match, inv_match;
  logic             lk_hit, fill_fire, set_full;
  logic [WAY_W-1:0] hit_way, fill_way, victim_way;
  fill_src_e        fill_src;

  assign lk_set  = set_of(lk_win);
  assign lk_tag  = tag_of(lk_win);
  assign fl_set  = set_of(fl_win);
  assign fl_tag  = tag_of(fl_win);
  assign inv_set = set_of(inv_win);
  assign inv_tag = tag_of(inv_win);

  uc_tag_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) lk_cmp_i (
    .vld(vld_q[lk_set]), .tags(tag_q[lk_set]), .tids(tid_q[lk_set]),
    .q_tag(lk_tag), .q_tid(lk_tid), .use_tid(1'b1), .match(lk_match));

  uc_tag_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) fl_cmp_i (
    .vld(vld_q[fl_set]), .tags(tag_q[fl_set]), .tids(tid_q[fl_set]),
    .q_tag(fl_tag), .q_tid(fl_tid), .use_tid(1'b1), .match(fl_match));

  uc_tag_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) inv_cmp_i (
    .vld(vld_q[inv_set]), .tags(tag_q[inv_set]), .tids(tid_q[inv_set]),
    .q_tag(inv_tag), .q_tid(1'b0), .use_tid(1'b0), .match(inv_match));

  assign lk_hit    = lk_valid && (|lk_match);
  assign fl_ready  = !((lk_valid && (lk_set == fl_set)) || (inv_valid && (inv_set == fl_set)));
  assign fill_fire = fl_valid && fl_ready;
  assign set_full  = &vld_q[fl_set];

  uc_way_pick #(.NWAYS(NWAYS)) pick_i (
    .vld(vld_q[fl_set]), .match(fl_match), .victim(victim_way),
    .way(fill_way), .src(fill_src));

  uc_plru #(.NSETS(NSETS), .NWAYS(NWAYS)) plru_i (
    .clk(clk), .rst_n(rst_n),
    .vic_set(fl_set), .vic_way(victim_way),
    .ta_en(lk_hit), .ta_set(lk_set), .ta_way(hit_way),
    .tb_en(fill_fire), .tb_set(fl_set), .tb_way(fill_way));

  // read selection from the single matching way
  logic              sel_uc;
  logic [CNT_W-1:0]  sel_cnt;
  logic [LINE_W-1:0] sel_dat;

  always_comb begin
    sel_uc  = 1'b0;
    sel_cnt = '0;
    sel_dat = '0;
    hit_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (lk_match[w]) begin
        sel_uc  = sel_uc | uc_q[lk_set][w];
        sel_cnt = sel_cnt | cnt_q[lk_set][w];
        sel_dat = sel_dat | dat_q[lk_set][w];
        hit_way = hit_way | WAY_W'(w);
      end
    end
  end

  // valid bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
    end else begin
      if (fill_fire) vld_q[fl_set][fill_way] <= 1'b1;
      if (inv_valid) vld_q[inv_set] <= vld_q[inv_set] & ~inv_match;
    end
  end

  // line payload
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[fl_set][fill_way] <= fl_tag;
      tid_q[fl_set][fill_way] <= fl_tid;
      uc_q[fl_set][fill_way]  <= fl_ucode;
      cnt_q[fl_set][fill_way] <= fl_count;
      dat_q[fl_set][fill_way] <= fl_uops;
    end
  end

  // result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_hit      <= 1'b0;
      rd_ucode    <= 1'b0;
      rd_slot_vld <= '0;
      rd_uops     <= '0;
    end else begin
      rd_valid    <= lk_valid;
      rd_hit      <= lk_hit;
      rd_ucode    <= lk_hit && sel_uc;
      rd_slot_vld <= lk_hit ? slot_mask(sel_cnt) : '0;
      rd_uops     <= lk_hit ? (sel_dat & lane_mask(slot_mask(sel_cnt))) : '0;
    end
  end
endmodule

// File: rtl/uopc_cache_chk.sv
module uopc_cache_chk import uc_pkg::*; #(
  parameter int unsigned NWAYS  = 8,
  parameter int unsigned SET_W  = 6,
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned LINE_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              fl_valid,
  input logic [SET_W-1:0]  lk_set,
  input logic [SET_W-1:0]  fl_set,
  input logic [NWAYS-1:0]  lk_match,
  input logic              fill_fire,
  input fill_src_e         fill_src,
  input logic              set_full,
  input logic              rd_valid,
  input logic              rd_hit,
  input logic              rd_ucode,
  input logic [SLOTS-1:0]  rd_slot_vld,
  input logic [LINE_W-1:0] rd_uops
);
  AST_ONE_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_match)); // R6

  AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fl_valid && (lk_set == fl_set)) |-> !fill_fire); // R9

  AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_slot_vld[0] && (((rd_slot_vld + 1'b1) & rd_slot_vld) == '0))); // R3

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_hit) |-> ((rd_slot_vld == '0) && (rd_uops == '0) && !rd_ucode)); // R3

  AST_VICTIM_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && (fill_src == FW_VICTIM)) |-> set_full); // R6

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_valid && $past(lk_valid))); // R2
endmodule

bind uopc_cache uopc_cache_chk #(
  .NWAYS(NWAYS), .SET_W(SET_W), .SLOTS(SLOTS), .LINE_W(LINE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fl_valid(fl_valid),
  .lk_set(lk_set), .fl_set(fl_set), .lk_match(lk_match),
  .fill_fire(fill_fire), .fill_src(fill_src), .set_full(set_full),
  .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_ucode(rd_ucode),
  .rd_slot_vld(rd_slot_vld), .rd_uops(rd_uops)
);

// File: tb/uopc_cache_tb_top.sv
module uopc_cache_tb_top;
  localparam int NS = 48;
  localparam int NW = 8;
  localparam int SL = 6;
  localparam int UW = 16;
  localparam int WW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          lk_valid = 0, lk_tid = 0, fl_valid = 0, fl_tid = 0, fl_ucode = 0, inv_valid = 0;
  logic [WW-1:0] lk_win = '0, fl_win = '0, inv_win = '0;
  logic [2:0]    fl_count = '0;
  logic [95:0]   fl_uops = '0;
  logic          fl_ready, rd_valid, rd_hit, rd_ucode;
  logic [5:0]    rd_slot_vld;
  logic [95:0]   rd_uops;

  uopc_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_win(lk_win),
    .fl_valid(fl_valid), .fl_tid(fl_tid), .fl_win(fl_win),
    .fl_count(fl_count), .fl_ucode(fl_ucode), .fl_uops(fl_uops), .fl_ready(fl_ready),
    .inv_valid(inv_valid), .inv_win(inv_win),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_ucode(rd_ucode),
    .rd_slot_vld(rd_slot_vld), .rd_uops(rd_uops));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  bit          m_v   [NS][NW];
  int          m_tag [NS][NW];
  bit          m_tid [NS][NW];
  bit          m_uc  [NS][NW];
  int          m_cnt [NS][NW];
  logic [95:0] m_dat [NS][NW];
  bit [6:0]    m_tree[NS];

  logic        exp_valid = 0, exp_hit = 0, exp_uc = 0;
  logic [5:0]  exp_slots = '0;
  logic [95:0] exp_uops = '0;

  // pending stimulus
  bit s_lkv, s_lkt, s_flv, s_flt, s_flu, s_ivv;
  int s_lkw, s_flw, s_flc, s_ivw;
  logic [95:0] s_fld;

  function automatic int win(int s, int t);
    return t * NS + s;
  endfunction

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(int s, int tg, bit t);
    for (int w = 0; w < NW; w++)
      if (m_v[s][w] && m_tag[s][w] == tg && m_tid[s][w] == t) return w;
    return -1;
  endfunction

  // tree replacement restated by halving way ranges
  function automatic int m_victim(int s);
    int lo = 0, size = NW, k = 0;
    while (size > 1) begin
      size = size / 2;
      if (m_tree[s][k]) begin lo = lo + size; k = 2 * k + 2; end
      else k = 2 * k + 1;
    end
    return lo;
  endfunction

  task automatic m_touch(int s, int w);
    int lo = 0, size = NW, k = 0;
    while (size > 1) begin
      size = size / 2;
      if (w >= lo + size) begin m_tree[s][k] = 1'b0; lo = lo + size; k = 2 * k + 2; end
      else begin m_tree[s][k] = 1'b1; k = 2 * k + 1; end
    end
  endtask

  task automatic lk(bit t, int w);
    s_lkv = 1; s_lkt = t; s_lkw = w;
  endtask

  task automatic fl(bit t, int w, int c, bit u, logic [95:0] d);
    s_flv = 1; s_flt = t; s_flw = w; s_flc = c; s_flu = u; s_fld = d;
  endtask

  task automatic iv(int w);
    s_ivv = 1; s_ivw = w;
  endtask

  task automatic tick();
    int ls, lt, fs, ft, is_, it, hw, fw;
    bit rdy;
    @(negedge clk);
    chk("R2", "rd_valid", 128'(rd_valid), 128'(exp_valid));
    chk("R2", "rd_hit", 128'(rd_hit), 128'(exp_hit));
    chk("R3", "rd_slot_vld", 128'(rd_slot_vld), 128'(exp_slots));
    chk("R3", "rd_uops", 128'(rd_uops), 128'(exp_uops));
    chk("R4", "rd_ucode", 128'(rd_ucode), 128'(exp_uc));
    lk_valid = s_lkv; lk_tid = s_lkt; lk_win = WW'(s_lkw);
    fl_valid = s_flv; fl_tid = s_flt; fl_win = WW'(s_flw);
    fl_count = 3'(s_flc); fl_ucode = s_flu; fl_uops = s_fld;
    inv_valid = s_ivv; inv_win = WW'(s_ivw);
    #1;
    ls = s_lkw % NS; lt = s_lkw / NS;
    fs = s_flw % NS; ft = s_flw / NS;
    is_ = s_ivw % NS; it = s_ivw / NS;
    rdy = !((s_lkv && ls == fs) || (s_ivv && is_ == fs));
    chk("R9", "fl_ready", 128'(fl_ready), 128'(rdy));
    // expected lookup result from state before this edge
    exp_valid = s_lkv; exp_hit = 0; exp_uc = 0; exp_slots = '0; exp_uops = '0;
    hw = s_lkv ? m_find(ls, lt, s_lkt) : -1;
    if (hw >= 0) begin
      exp_hit = 1;
      exp_uc = m_uc[ls][hw];
      exp_uops = m_dat[ls][hw];
      for (int i = 0; i < SL; i++) begin
        if (i < m_cnt[ls][hw]) exp_slots[i] = 1'b1;
        else exp_uops[i*UW +: UW] = '0;
      end
    end
    if (hw >= 0) m_touch(ls, hw);
    if (s_flv && rdy) begin
      fw = m_find(fs, ft, s_flt);
      if (fw < 0) for (int w = NW - 1; w >= 0; w--) if (!m_v[fs][w]) fw = w;
      if (fw < 0) fw = m_victim(fs);
      m_v[fs][fw] = 1; m_tag[fs][fw] = ft; m_tid[fs][fw] = s_flt;
      m_uc[fs][fw] = s_flu; m_cnt[fs][fw] = s_flc; m_dat[fs][fw] = s_fld;
      m_touch(fs, fw);
    end
    if (s_ivv)
      for (int w = 0; w < NW; w++) if (m_v[is_][w] && m_tag[is_][w] == it) m_v[is_][w] = 0;
    s_lkv = 0; s_flv = 0; s_ivv = 0;
  endtask

  // one lookup, then a hand-stated hit/miss one rising edge later
  task automatic probe(input string req, bit t, int w, bit want);
    lk(t, w);
    tick();
    @(posedge clk);
    #1;
    chk(req, "probe hit", 128'(rd_hit), 128'(want));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < NW; w++) m_v[s][w] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state at the ports
    chk("R10", "rd_valid", 128'(rd_valid), 128'(0));
    chk("R10", "rd_hit", 128'(rd_hit), 128'(0));
    chk("R10", "rd_uops", 128'(rd_uops), 128'(0));
    probe("R10", 0, win(3, 2), 0);

    // R1 R2 R3: fill, then lookups in same and other sets
    fl(0, win(3, 2), 6, 0, rnd96()); tick();
    probe("R1", 0, win(3, 2), 1);
    chk("R2", "slot mask full line", 128'(rd_slot_vld), 128'(6'b111111));
    probe("R1", 0, win(3, 5), 0);
    probe("R1", 0, win(4, 2), 0);
    fl(1, win(9, 1), 3, 0, rnd96()); tick();
    lk(1, win(9, 1)); tick();
    @(posedge clk); #1;
    chk("R3", "slot mask count 3", 128'(rd_slot_vld), 128'(6'b000111));
    chk("R3", "upper slots zero", 128'(rd_uops[95:48]), 128'(0));

    // R5: other thread never hits
    probe("R5", 1, win(3, 2), 0);
    probe("R5", 0, win(9, 1), 0);

    // R4: microcode pointer flag
    fl(0, win(11, 4), 1, 1, rnd96()); tick();
    probe("R4", 0, win(11, 4), 1);
    chk("R4", "ucode flag", 128'(rd_ucode), 128'(1));

    // R5 R6 R7: one thread fills all ways of set 20, then evicts by tree
    for (int k = 0; k < NW; k++) begin fl(0, win(20, k), 1 + k % SL, 0, rnd96()); tick(); end
    for (int k = 0; k < NW; k++) probe("R5", 0, win(20, k), 1);
    probe("R7", 0, win(20, 0), 1);
    fl(0, win(20, 30), 4, 0, rnd96()); tick();
    probe("R7", 0, win(20, 4), 0);
    probe("R7", 0, win(20, 30), 1);
    probe("R7", 0, win(20, 0), 1);
    // R6: refill in place, nothing evicted
    fl(0, win(20, 1), 2, 1, rnd96()); tick();
    probe("R6", 0, win(20, 1), 1);
    chk("R6", "in-place count", 128'(rd_slot_vld), 128'(6'b000011));
    probe("R6", 0, win(20, 7), 1);
    probe("R6", 0, win(20, 2), 1);

    // R9: lookup and fill in one set; fill to another set proceeds
    lk(0, win(3, 2)); fl(0, win(3, 8), 5, 0, rnd96()); tick();
    probe("R9", 0, win(3, 8), 0);
    lk(0, win(3, 2)); fl(0, win(5, 8), 5, 0, rnd96()); tick();
    probe("R9", 0, win(5, 8), 1);
    iv(win(30, 0)); fl(0, win(30, 1), 2, 0, rnd96()); tick();
    probe("R9", 0, win(30, 1), 0);

    // R8: invalidation clears both threads; same-cycle lookup sees old state
    fl(0, win(14, 6), 2, 0, rnd96()); tick();
    fl(1, win(14, 6), 3, 0, rnd96()); tick();
    fl(0, win(14, 7), 3, 0, rnd96()); tick();
    lk(1, win(14, 6)); iv(win(14, 6)); tick();
    @(posedge clk); #1;
    chk("R8", "lookup before invalidate", 128'(rd_hit), 128'(1));
    probe("R8", 0, win(14, 6), 0);
    probe("R8", 1, win(14, 6), 0);
    probe("R8", 0, win(14, 7), 1);

    // mixed traffic on a few sets, compared every clock with the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(1, 0) == 1) lk(1'($urandom_range(1, 0)), win(5 + $urandom_range(2, 0), $urandom_range(11, 0)));
      if ($urandom_range(2, 0) == 0)
        fl(1'($urandom_range(1, 0)), win(5 + $urandom_range(2, 0), $urandom_range(11, 0)),
           $urandom_range(6, 1), 1'($urandom_range(1, 0)), rnd96());
      if ($urandom_range(15, 0) == 0) iv(win(5 + $urandom_range(2, 0), $urandom_range(11, 0)));
      tick();
    end
    tick();
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule